// File: doc/BRIEF.md
# Windowed Service Watchdog with Settings Lock

This block watches a pulsed service input and issues a reset pulse when the service pattern breaks. After reset it waits in a long open window for the first valid service pulse. A valid pulse starts a close window. Once the close window ends, an open window follows, and a valid pulse there starts the next close window. Three events fire a reset pulse of fixed length: a pulse inside the close window, the long open window running out, or an open window running out. When the reset pulse ends, the watchdog goes back to the long open window.

All window lengths are counted in ticks of a one-millisecond strobe supplied from outside. A service pulse only counts once it has stayed high for a minimum number of clock cycles, which is a parameter. The three window lengths and the output polarity are set through a small register write port. Setting a lock bit freezes these settings until the next reset. A restart flag and a saturating expiration counter remain clearable while the lock is set.

Top module: `wd_window_guard`

## Requirements
- R1: After reset the block is in the long open window, `wd_rst_o` is 0 (active-high polarity by default), `restart_flag_o` is 0, `exp_cnt_o` is 0 and `locked_o` is 0.
- R2: The long open window length comes from register address 0, bits [1:0]: 0=200, 1=600, 2=2000, 3=5000 ticks. If no valid service arrives before it ends, a reset pulse starts.
- R3: A service pulse is valid only once `svc_i` has been sampled high on MIN_PULSE_CYC consecutive clocks. A shorter pulse has no effect, even inside the close window.
- R4: A valid service in the long open window or an open window starts a close window. Its length comes from address 0 bits [3:2] (0=10, 1=20, 2=50, 3=100 ticks). The open window that follows takes its length from bits [5:4] (0=100, 1=200, 2=400, 3=800 ticks).
- R5: A valid service inside the close window starts a reset pulse.
- R6: An open window that ends with no valid service starts a reset pulse.
- R7: The reset pulse lasts 10 ticks and then the long open window begins. While the pulse is active, `wd_rst_o` equals address 1 bit 0 (1 = active high, 0 = active low). At all other times it holds the inverse of that bit.
- R8: Any write to address 0 or 1 during the long open window restarts that window's count from zero. A valid service in the same cycle takes priority.
- R9: Writing address 1 with bit 1 set raises `locked_o`. After that, writes to addresses 0 and 1 are ignored until reset.
- R10: Each entry into a reset pulse sets `restart_flag_o` and increments `exp_cnt_o`, which saturates at 15.
- R11: A write to address 2 clears the flag when bit 0 is set and clears the count when bit 1 is set. This works while locked. If the clear coincides with an entry into a reset pulse, the clear is applied first: the flag ends at 1 and the count at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| svc_i | input | 1 | Synchronized service input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| wd_rst_o | output | 1 | Reset output, polarity selectable |
| restart_flag_o | output | 1 | Sticky flag set on expiration |
| exp_cnt_o | output | 4 | Saturating expiration count |
| locked_o | output | 1 | Settings lock state |

## Verification
The risky collision is a status-clear write landing on the same clock edge as an expiration. That edge must both wipe and update the flag and the counter. The bench stops the automatic tick and drives ticks by hand. It counts the long window down to its final tick and issues the clear write together with that tick. It then expects the flag set, the count at exactly 1 (not 0 and not 2), and the reset output active. A behavioural reference model is also compared on every clock. It catches a second kind of overlap: a control write that restarts the long window arriving on the same cycle as a tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned TMR_W = 13;

  typedef enum logic [1:0] {
    WS_LONG  = 2'd0,
    WS_CLOSE = 2'd1,
    WS_OPEN  = 2'd2,
    WS_PULSE = 2'd3
  } wd_state_e;

  typedef struct packed {
    logic [1:0] long_sel;
    logic [1:0] close_sel;
    logic [1:0] open_sel;
    logic       pol_hi;
  } wd_cfg_t;

  localparam logic [1:0] ADR_WIN = 2'd0;
  localparam logic [1:0] ADR_CTL = 2'd1;
  localparam logic [1:0] ADR_CLR = 2'd2;

  function automatic logic [TMR_W-1:0] long_ticks(input logic [1:0] s);
    logic [TMR_W-1:0] v;
    case (s)
      2'd0:    v = TMR_W'(200);
      2'd1:    v = TMR_W'(600);
      2'd2:    v = TMR_W'(2000);
      default: v = TMR_W'(5000);
    endcase
    return v;
  endfunction

  function automatic logic [TMR_W-1:0] close_ticks(input logic [1:0] s);
    logic [TMR_W-1:0] v;
    case (s)
      2'd0:    v = TMR_W'(10);
      2'd1:    v = TMR_W'(20);
      2'd2:    v = TMR_W'(50);
      default: v = TMR_W'(100);
    endcase
    return v;
  endfunction

  function automatic logic [TMR_W-1:0] open_ticks(input logic [1:0] s);
    // doubling steps from 100 ticks
    return TMR_W'(100) << s;
  endfunction
endpackage

// File: rtl/wdt_svc_qual.sv
module wdt_svc_qual #(
  parameter int MIN_CYC = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic svc_i,
  output logic ok_o
);
  localparam int CNT_W = $clog2(MIN_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYC - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(MIN_CYC);

  logic [CNT_W-1:0] hi_cnt;

  // one strobe per pulse, on the clock the width requirement is met
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      ok_o   <= 1'b0;
    end else begin
      ok_o <= svc_i && (hi_cnt == LAST);
      if (!svc_i)
        hi_cnt <= '0;
      else if (hi_cnt != TOP)
        hi_cnt <= hi_cnt + 1'b1;
    end
  end

  // R3: a strobe is only seen after the input was high
  a_r3_strobe_needs_high: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> $past(svc_i));
  // R3: never two strobes in a row
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
    ok_o |=> !ok_o);
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_pkg::*;
#(
  parameter int         ADDR_W     = 2,
  parameter int         DATA_W     = 8,
  parameter logic [1:0] DEF_LONG   = 2'd0,
  parameter logic [1:0] DEF_CLOSE  = 2'd0,
  parameter logic [1:0] DEF_OPEN   = 2'd0,
  parameter logic       DEF_POL_HI = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wd_cfg_t           cfg_o,
  output logic              locked_o,
  output logic              touch_o,
  output logic              clr_flag_o,
  output logic              clr_cnt_o
);
  logic hit_win, hit_ctl, hit_clr;
  logic unused_hi;

  assign hit_win    = wr_en && (wr_addr == ADDR_W'(ADR_WIN));
  assign hit_ctl    = wr_en && (wr_addr == ADDR_W'(ADR_CTL));
  assign hit_clr    = wr_en && (wr_addr == ADDR_W'(ADR_CLR));
  assign touch_o    = hit_win || hit_ctl;
  assign clr_flag_o = hit_clr && wr_data[0];
  assign clr_cnt_o  = hit_clr && wr_data[1];
  assign unused_hi  = ^wr_data[DATA_W-1:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o    <= '{long_sel: DEF_LONG, close_sel: DEF_CLOSE,
                    open_sel: DEF_OPEN, pol_hi: DEF_POL_HI};
      locked_o <= 1'b0;
    end else if (!locked_o) begin
      if (hit_win) begin
        cfg_o.long_sel  <= wr_data[1:0];
        cfg_o.close_sel <= wr_data[3:2];
        cfg_o.open_sel  <= wr_data[5:4];
      end
      if (hit_ctl) begin
        cfg_o.pol_hi <= wr_data[0];
        locked_o     <= wr_data[1];
      end
    end
  end

  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> locked_o);
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    locked_o |=> $stable(cfg_o));
endmodule

// File: rtl/wdt_window_fsm.sv
module wdt_window_fsm
  import wdt_pkg::*;
#(
  parameter int   CNT_W       = 4,
  parameter int   PULSE_TICKS = 10,
  parameter logic DEF_POL_HI  = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             svc_ok_i,
  input  logic             touch_i,
  input  logic             clr_flag_i,
  input  logic             clr_cnt_i,
  input  wd_cfg_t          cfg_i,
  output logic             wd_rst_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TMR_W-1:0] PLEN    = TMR_W'(PULSE_TICKS);

  wd_state_e        st, st_n;
  logic [TMR_W-1:0] tmr, tmr_n, cur_len;
  logic             last, expire;
  logic [CNT_W-1:0] cnt_base;

  always_comb begin
    case (st)
      WS_LONG:  cur_len = long_ticks(cfg_i.long_sel);
      WS_CLOSE: cur_len = close_ticks(cfg_i.close_sel);
      WS_OPEN:  cur_len = open_ticks(cfg_i.open_sel);
      default:  cur_len = PLEN;
    endcase
  end

  assign last = tick_i && (tmr == cur_len - TMR_W'(1));

  always_comb begin
    st_n   = st;
    tmr_n  = tmr;
    expire = 1'b0;
    case (st)
      WS_LONG, WS_OPEN: begin
        if (svc_ok_i) begin
          st_n  = WS_CLOSE;
          tmr_n = '0;
        end else if (touch_i && st == WS_LONG) begin
          tmr_n = '0;
        end else if (last) begin
          st_n   = WS_PULSE;
          tmr_n  = '0;
          expire = 1'b1;
        end else if (tick_i) begin
          tmr_n = tmr + 1'b1;
        end
      end
      WS_CLOSE: begin
        if (svc_ok_i) begin
          st_n   = WS_PULSE;
          tmr_n  = '0;
          expire = 1'b1;
        end else if (last) begin
          st_n  = WS_OPEN;
          tmr_n = '0;
        end else if (tick_i) begin
          tmr_n = tmr + 1'b1;
        end
      end
      default: begin
        if (last) begin
          st_n  = WS_LONG;
          tmr_n = '0;
        end else if (tick_i) begin
          tmr_n = tmr + 1'b1;
        end
      end
    endcase
  end

  assign cnt_base = clr_cnt_i ? '0 : cnt_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= WS_LONG;
      tmr      <= '0;
      flag_o   <= 1'b0;
      cnt_o    <= '0;
      wd_rst_o <= ~DEF_POL_HI;
    end else begin
      st       <= st_n;
      tmr      <= tmr_n;
      wd_rst_o <= (st_n == WS_PULSE) ? cfg_i.pol_hi : ~cfg_i.pol_hi;
      if (expire)
        flag_o <= 1'b1;
      else if (clr_flag_i)
        flag_o <= 1'b0;
      if (expire && cnt_base != CNT_MAX)
        cnt_o <= cnt_base + 1'b1;
      else
        cnt_o <= cnt_base;
    end
  end

  a_r5_early_service: assert property (@(posedge clk) disable iff (rst)
    (st == WS_CLOSE && svc_ok_i) |=> st == WS_PULSE);
  a_r7_pulse_exit: assert property (@(posedge clk) disable iff (rst)
    (st == WS_PULSE) |=> (st == WS_PULSE || st == WS_LONG));
  a_r7_pulse_level: assert property (@(posedge clk) disable iff (rst)
    (st == WS_PULSE && $stable(cfg_i.pol_hi)) |-> wd_rst_o == cfg_i.pol_hi);
  a_r10_flag_on_entry: assert property (@(posedge clk) disable iff (rst)
    (st != WS_PULSE) ##1 (st == WS_PULSE) |-> flag_o);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == CNT_MAX && !clr_cnt_i) |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/wd_window_guard.sv
module wd_window_guard
  import wdt_pkg::*;
#(
  parameter int         MIN_PULSE_CYC = 20000,
  parameter int         PULSE_TICKS   = 10,
  parameter int         CNT_W         = 4,
  parameter int         ADDR_W        = 2,
  parameter int         DATA_W        = 8,
  parameter logic [1:0] DEF_LONG      = 2'd0,
  parameter logic [1:0] DEF_CLOSE     = 2'd0,
  parameter logic [1:0] DEF_OPEN      = 2'd0,
  parameter logic       DEF_POL_HI    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_ms,
  input  logic              svc_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wd_rst_o,
  output logic              restart_flag_o,
  output logic [CNT_W-1:0]  exp_cnt_o,
  output logic              locked_o
);
  wd_cfg_t cfg;
  logic    svc_ok, touch, clr_flag, clr_cnt;

  wdt_svc_qual #(.MIN_CYC(MIN_PULSE_CYC)) u_qual (
    .clk(clk), .rst(rst), .svc_i(svc_i), .ok_o(svc_ok)
  );

  wdt_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEF_LONG(DEF_LONG),
    .DEF_CLOSE(DEF_CLOSE), .DEF_OPEN(DEF_OPEN), .DEF_POL_HI(DEF_POL_HI)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg), .locked_o(locked_o),
    .touch_o(touch), .clr_flag_o(clr_flag), .clr_cnt_o(clr_cnt)
  );

  wdt_window_fsm #(
    .CNT_W(CNT_W), .PULSE_TICKS(PULSE_TICKS), .DEF_POL_HI(DEF_POL_HI)
  ) u_fsm (
    .clk(clk), .rst(rst), .tick_i(tick_ms), .svc_ok_i(svc_ok),
    .touch_i(touch), .clr_flag_i(clr_flag), .clr_cnt_i(clr_cnt),
    .cfg_i(cfg), .wd_rst_o(wd_rst_o), .flag_o(restart_flag_o),
    .cnt_o(exp_cnt_o)
  );
endmodule

// File: tb/test_wd_window_guard.sv
`timescale 1ns/1ps
module test_wd_window_guard;
  localparam int MINC = 6;
  localparam int TDIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       svc = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick_auto = 1'b1;
  logic       tick_man = 1'b0;
  logic       auto_t = 1'b0;
  logic       tick;
  logic       wd_rst_o, flag_o, locked_o;
  logic [3:0] cnt_o;

  int nchk = 0, nerr = 0, div = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign tick = tick_auto ? auto_t : tick_man;

  always @(negedge clk) begin
    div    = (div + 1) % TDIV;
    auto_t = (div == 0);
  end

  wd_window_guard #(.MIN_PULSE_CYC(MINC)) i_wd_window_guard (
    .clk(clk), .rst(rst), .tick_ms(tick), .svc_i(svc), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wd_rst_o(wd_rst_o),
    .restart_flag_o(flag_o), .exp_cnt_o(cnt_o), .locked_o(locked_o)
  );

  // ---------------- behavioural reference ----------------
  int lt[4] = '{200, 600, 2000, 5000};
  int ct[4] = '{10, 20, 50, 100};
  int ot[4] = '{100, 200, 400, 800};
  int m_st, m_tmr, m_long, m_close, m_open, m_cnt, m_hi;
  bit m_pol, m_lock, m_flag, m_out, m_ok;
  int len, nst, ntmr;
  bit exp_e, fin, touch;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_tmr = 0; m_long = 0; m_close = 0; m_open = 0;
      m_pol = 1; m_lock = 0; m_flag = 0; m_cnt = 0; m_out = 0;
      m_hi = 0; m_ok = 0;
    end else begin
      len   = (m_st == 0) ? lt[m_long] : (m_st == 1) ? ct[m_close] :
              (m_st == 2) ? ot[m_open] : 10;
      fin   = tick && (m_tmr == len - 1);
      touch = wr_en && (wr_addr < 2);
      nst = m_st; ntmr = m_tmr; exp_e = 0;
      if (m_st == 3) begin
        if (fin) begin nst = 0; ntmr = 0; end
        else if (tick) ntmr = m_tmr + 1;
      end else if (m_ok) begin
        if (m_st == 1) begin nst = 3; exp_e = 1; end
        else nst = 1;
        ntmr = 0;
      end else if (m_st == 0 && touch) begin
        ntmr = 0;
      end else if (fin) begin
        ntmr = 0;
        if (m_st == 1) nst = 2;
        else begin nst = 3; exp_e = 1; end
      end else if (tick) ntmr = m_tmr + 1;
      if (wr_en && wr_addr == 2) begin
        if (wr_data[0]) m_flag = 0;
        if (wr_data[1]) m_cnt = 0;
      end
      if (exp_e) begin
        m_flag = 1;
        if (m_cnt < 15) m_cnt = m_cnt + 1;
      end
      m_out = (nst == 3) ? m_pol : !m_pol;
      m_st = nst; m_tmr = ntmr;
      m_ok = svc && (m_hi == MINC - 1);
      m_hi = svc ? ((m_hi < MINC) ? m_hi + 1 : m_hi) : 0;
      if (wr_en && !m_lock) begin
        if (wr_addr == 0) begin
          m_long = wr_data[1:0]; m_close = wr_data[3:2]; m_open = wr_data[5:4];
        end else if (wr_addr == 1) begin
          m_pol = wr_data[0]; m_lock = wr_data[1];
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R7 reset output vs model", int'(wd_rst_o), int'(m_out));
      chk("R10 flag vs model", int'(flag_o), int'(m_flag));
      chk("R10 count vs model", int'(cnt_o), m_cnt);
      chk("R9 lock vs model", int'(locked_o), int'(m_lock));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); svc = 1'b1;
    repeat (n) @(negedge clk);
    svc = 1'b0;
  endtask

  task automatic mticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_man = 1'b1;
      @(negedge clk); tick_man = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    cyc(5); rst = 1'b0; cyc(2);
    chk("R1 reset output idle", int'(wd_rst_o), 0);
    chk("R1 flag clear", int'(flag_o), 0);
    chk("R1 count zero", int'(cnt_o), 0);
    chk("R1 unlocked", int'(locked_o), 0);
    // long window expiry at default length
    cyc(1620);
    chk("R2 long expiry pulse", int'(wd_rst_o), 1);
    chk("R10 count after expiry", int'(cnt_o), 1);
    chk("R10 flag after expiry", int'(flag_o), 1);
    cyc(100);
    chk("R7 pulse ends", int'(wd_rst_o), 0);
    // short pulse in close window is ignored
    pulse(8); cyc(20); pulse(4); cyc(100);
    chk("R3 short pulse ignored", int'(cnt_o), 1);
    pulse(8); cyc(4);
    chk("R4 service in open window", int'(wd_rst_o), 0);
    cyc(200); pulse(8); cyc(4);
    chk("R4 repeated service", int'(cnt_o), 1);
    // early service
    cyc(10); pulse(8); cyc(4);
    chk("R5 early service pulse", int'(wd_rst_o), 1);
    chk("R5 early service count", int'(cnt_o), 2);
    cyc(100);
    // open timeout
    pulse(8); cyc(900);
    chk("R6 open timeout pulse", int'(wd_rst_o), 1);
    chk("R6 open timeout count", int'(cnt_o), 3);
    cyc(100);
    // polarity
    wr(2'd1, 8'h00); cyc(3);
    chk("R7 active-low idle", int'(wd_rst_o), 1);
    pulse(8); cyc(10); pulse(8); cyc(4);
    chk("R7 active-low pulse", int'(wd_rst_o), 0);
    cyc(100); wr(2'd1, 8'h01);
    // reload by writes
    for (int i = 0; i < 4; i++) begin cyc(1200); wr(2'd0, 8'h00); end
    chk("R8 reload keeps window", int'(cnt_o), 4);
    cyc(1700);
    chk("R8 expiry after last reload", int'(cnt_o), 5);
    cyc(100);
    wr(2'd0, 8'h01); cyc(4000);
    chk("R2 longer window not yet", int'(cnt_o), 5);
    cyc(820);
    chk("R2 longer window expiry", int'(wd_rst_o), 1);
    cyc(100); wr(2'd0, 8'h04);
    pulse(8); cyc(120); pulse(8); cyc(4);
    chk("R4 longer close window", int'(cnt_o), 7);
    cyc(100); wr(2'd0, 8'h00);
    // lock
    wr(2'd1, 8'h03); cyc(2);
    chk("R9 lock set", int'(locked_o), 1);
    wr(2'd1, 8'h00); cyc(3);
    chk("R9 polarity write ignored", int'(wd_rst_o), 0);
    wr(2'd0, 8'h04);
    pulse(8); cyc(120); pulse(8); cyc(4);
    chk("R9 window write ignored", int'(cnt_o), 7);
    wr(2'd2, 8'h03); cyc(2);
    chk("R11 flag cleared under lock", int'(flag_o), 0);
    chk("R11 count cleared under lock", int'(cnt_o), 0);
    cyc(30000);
    chk("R10 count saturates", int'(cnt_o), 15);
    // coincident clear and expiry
    tick_auto = 1'b0;
    @(negedge clk); rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
    chk("R9 lock cleared by reset", int'(locked_o), 0);
    chk("R1 count after reset", int'(cnt_o), 0);
    mticks(200); mticks(10); mticks(199);
    chk("R11 count before collision", int'(cnt_o), 1);
    @(negedge clk); tick_man = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h03;
    @(negedge clk); tick_man = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    cyc(1);
    chk("R11 collision count", int'(cnt_o), 1);
    chk("R11 collision flag", int'(flag_o), 1);
    chk("R11 collision pulse", int'(wd_rst_o), 1);
    done = 1;
    finish_run();
  end
endmodule